// File: doc/BRIEF.md
# Halt and Wake Controller

This block decides when a small microcontroller core stops and when it runs again. A core write to the halt-control bit removes the core clock enable, which freezes the core. Four asynchronous sources can end the halt: the external reset pin, a brown-out detect, a multi-input wakeup pulse, and a rising edge on the G7 pin.

Every source passes through a two-flop synchronizer. The winning source is chosen by a fixed priority and recorded as status. The block then tells the core to restart at address 0x0000 or to resume at the instruction after the halt.

A crystal oscillator needs time to settle. When a wakeup or a brown-out ends a halt with the crystal option selected, the block keeps the core stopped for 256 instruction-cycle ticks before it releases it. The tick is the oscillator clock divided by ten. During that wait the watchdog prescaler counts down. Every exit presets the watchdog prescaler and counter to all ones, whichever clock option is in use.

Top module: `hw_halt_ctrl`

## Requirements
- R1: After reset:
  - `core_clk_en_o` is 1 and `halted_o` is 0.
  - `restart_o` and `resume_o` are 0.
  - `wake_src_o` is 0, and `wdt_pre_o` and `wdt_cnt_o` are 0.
- R2: A `halt_wr_i` pulse sampled while running clears `core_clk_en_o` and sets `halted_o` from the next cycle. Both stay that way until a valid wake event arrives.
- R3: `tc_tick_o` is high for exactly one oscillator cycle in every 10, and it runs in all states.
- R4: When an exit needs no settle delay, `core_clk_en_o` returns to 1 after the third rising clock edge that follows the wake input change.
- R5: A G7 rising edge ends a halt only when `clk_opt_i` is 1 (RC) or 2 or 3 (external). With `clk_opt_i` = 0 (crystal) it is ignored.
- R6: A brown-out detect ends a halt only when `bo_en_i` is 1. With `bo_en_i` = 0 it has no effect.
- R7: When several sources are active together, the winner is chosen by a fixed priority. The winner is reported on `wake_src_o` until the next exit.

  | Priority | Source | `wake_src_o` code |
  |---|---|---|
  | 1 (highest) | reset pin | 0 |
  | 2 | brown-out | 1 |
  | 3 | multi-input wakeup | 2 |
  | 4 (lowest) | G7 | 3 |

- R8: Exactly one of `restart_o` or `resume_o` pulses, for one cycle, in the first cycle in which `core_clk_en_o` is high again.
  - `restart_o` pulses for a reset-pin or brown-out exit.
  - `resume_o` pulses for a multi-input wakeup or G7 exit.
- R9: Every exit leaves `wdt_pre_o` and `wdt_cnt_o` at 0xFF, with any clock option.
- R10: With the crystal option, a multi-input wakeup or brown-out exit keeps `core_clk_en_o` low while exactly 256 `tc_tick_o` pulses occur.
- R11: A reset-pin exit never uses the settle delay, even with the crystal option.
- R12: While running, the wake inputs (G7, wakeup, brown-out, reset pin) have no effect on `core_clk_en_o`, `restart_o` or `resume_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the controller |
| clk_opt_i | input | 2 | Clock option strap: 0 crystal, 1 RC, 2 or 3 external |
| bo_en_i | input | 1 | Brown-out enable strap |
| halt_wr_i | input | 1 | Core writes 1 to the halt-control bit |
| g7_i | input | 1 | G7 pin, asynchronous |
| mwake_i | input | 1 | Multi-input wakeup request, asynchronous |
| reset_pin_ni | input | 1 | External reset pin, active low, asynchronous |
| bo_det_i | input | 1 | Brown-out detect, asynchronous |
| core_clk_en_o | output | 1 | Core clock enable |
| tc_tick_o | output | 1 | Instruction-cycle tick, one cycle in 10 |
| restart_o | output | 1 | Pulse: restart at address 0x0000 |
| resume_o | output | 1 | Pulse: resume after the halt instruction |
| halted_o | output | 1 | Core is stopped (halt or settle) |
| wake_src_o | output | 2 | Source of the most recent exit |
| wdt_pre_o | output | 8 | Watchdog prescaler value |
| wdt_cnt_o | output | 8 | Watchdog counter value |

## Verification
- The bench drives each wake input just after a falling clock edge.
- Two synchronizer stages and the state register lie on the path, so a direct exit is due after the third following rising edge. The bench samples the clock enable, the restart or resume pulse, the status and the watchdog values at the falling edge after that rising edge.
- For a settled crystal exit, the bench counts the ticks it sees at falling edges while the enable is low, starting at that same falling edge. It expects the enable and the pulse to appear together once 256 ticks have been counted.
- Halt entry is checked one falling edge after the write pulse. Ignored sources are checked by holding them for several cycles beyond the three-edge latency and confirming that the enable stays unchanged.

// File: rtl/hw_halt_pkg.sv
package hw_halt_pkg;
  localparam logic [1:0] CLK_XTAL = 2'd0;

  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_BOR = 2'd1,
    SRC_MWK = 2'd2,
    SRC_G7  = 2'd3
  } wake_src_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } hstate_e;
endpackage

// File: rtl/hw_sync.sv
module hw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hw_tc_div.sv
module hw_tc_div #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hw_settle_timer.sv
module hw_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preset_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] pre_q, cnt_q;

  // prescaler counts settle ticks; counter only takes the preset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (preset_i) begin
      pre_q <= '1;
      cnt_q <= '1;
    end else if (run_i && tick_i) begin
      pre_q <= pre_q - 1'b1;
    end
  end

  assign wrap_o = run_i && tick_i && (pre_q == '0);
  assign pre_o  = pre_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/hw_halt_ctrl.sv
module hw_halt_ctrl
  import hw_halt_pkg::*;
#(
  parameter int DIV         = 10,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       clk_opt_i,
  input  logic             bo_en_i,
  input  logic             halt_wr_i,
  input  logic             g7_i,
  input  logic             mwake_i,
  input  logic             reset_pin_ni,
  input  logic             bo_det_i,
  output logic             core_clk_en_o,
  output logic             tc_tick_o,
  output logic             restart_o,
  output logic             resume_o,
  output logic             halted_o,
  output logic [1:0]       wake_src_o,
  output logic [WDT_W-1:0] wdt_pre_o,
  output logic [WDT_W-1:0] wdt_cnt_o
);
  localparam int NSRC = 4;
  // reset pin idles high, the rest idle low
  localparam logic [NSRC-1:0] SYNC_RST = 4'b0001;

  logic [NSRC-1:0] raw, syn;
  assign raw = {g7_i, mwake_i, bo_det_i, reset_pin_ni};

  for (genvar i = 0; i < NSRC; i++) begin : g_sync
    hw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (syn[i])
    );
  end

  logic tick, wrap;
  hw_tc_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  hstate_e   state_q, state_d;
  wake_src_e src_q, sel_src;
  logic      g7_prev_q, restart_q, resume_q;
  logic      ev_rst, ev_bor, ev_mwk, ev_g7, any_ev, is_xtal, need_settle;
  logic      preset, release_w;
  wake_src_e rel_src;

  assign is_xtal = (clk_opt_i == CLK_XTAL);
  assign ev_rst  = ~syn[0];
  assign ev_bor  = bo_en_i & syn[1];
  assign ev_mwk  = syn[2];
  assign ev_g7   = syn[3] & ~g7_prev_q & ~is_xtal;
  assign any_ev  = ev_rst | ev_bor | ev_mwk | ev_g7;

  always_comb begin
    if (ev_rst)      sel_src = SRC_RST;
    else if (ev_bor) sel_src = SRC_BOR;
    else if (ev_mwk) sel_src = SRC_MWK;
    else             sel_src = SRC_G7;
  end

  assign need_settle = is_xtal && (sel_src == SRC_BOR || sel_src == SRC_MWK);
  assign preset      = (state_q == ST_HALT) && any_ev;
  assign release_w   = (preset && !need_settle) || ((state_q == ST_SETTLE) && wrap);
  assign rel_src     = (state_q == ST_HALT) ? sel_src : src_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (halt_wr_i) state_d = ST_HALT;
      ST_HALT:   if (any_ev) state_d = need_settle ? ST_SETTLE : ST_RUN;
      ST_SETTLE: if (wrap) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      src_q     <= SRC_RST;
      g7_prev_q <= 1'b0;
      restart_q <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      g7_prev_q <= syn[3];
      if (preset) src_q <= sel_src;
      restart_q <= release_w && (rel_src == SRC_RST || rel_src == SRC_BOR);
      resume_q  <= release_w && (rel_src == SRC_MWK || rel_src == SRC_G7);
    end
  end

  hw_settle_timer #(.W(WDT_W)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .preset_i(preset),
    .run_i   (state_q == ST_SETTLE),
    .tick_i  (tick),
    .pre_o   (wdt_pre_o),
    .cnt_o   (wdt_cnt_o),
    .wrap_o  (wrap)
  );

  assign core_clk_en_o = (state_q == ST_RUN);
  assign halted_o      = (state_q != ST_RUN);
  assign tc_tick_o     = tick;
  assign restart_o     = restart_q;
  assign resume_o      = resume_q;
  assign wake_src_o    = src_q;
endmodule

// File: rtl/hw_halt_ctrl_chk.sv
module hw_halt_ctrl_chk #(
  parameter int WDT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_wr_i,
  input logic             core_clk_en_o,
  input logic             tc_tick_o,
  input logic             restart_o,
  input logic             resume_o,
  input logic [1:0]       wake_src_o,
  input logic [WDT_W-1:0] wdt_pre_o,
  input logic [WDT_W-1:0] wdt_cnt_o
);
  // R2
  halt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clk_en_o && halt_wr_i) |=> !core_clk_en_o);

  // R2
  fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> $past(halt_wr_i));

  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_tick_o |=> !tc_tick_o);

  // R8
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> (restart_o ^ resume_o));

  // R8
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_o && resume_o));

  // R7
  restart_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !wake_src_o[1]);

  // R7
  resume_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> wake_src_o[1]);

  // R9
  wdt_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o || resume_o) |-> (&wdt_pre_o && &wdt_cnt_o));
endmodule

bind hw_halt_ctrl hw_halt_ctrl_chk #(.WDT_W(WDT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .halt_wr_i    (halt_wr_i),
  .core_clk_en_o(core_clk_en_o),
  .tc_tick_o    (tc_tick_o),
  .restart_o    (restart_o),
  .resume_o     (resume_o),
  .wake_src_o   (wake_src_o),
  .wdt_pre_o    (wdt_pre_o),
  .wdt_cnt_o    (wdt_cnt_o)
);

// File: tb/hw_halt_ctrl_bench.sv
module hw_halt_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_opt = 2'd1;
  logic       bo_en = 1'b0, halt_wr = 1'b0, g7 = 1'b0, mwake = 1'b0;
  logic       rstpin_n = 1'b1, bo_det = 1'b0;
  logic       en, tick, restart, resume, halted;
  logic [1:0] wsrc;
  logic [7:0] pre, cnt;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hw_halt_ctrl u_hw_halt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clk_opt_i(clk_opt), .bo_en_i(bo_en),
    .halt_wr_i(halt_wr), .g7_i(g7), .mwake_i(mwake), .reset_pin_ni(rstpin_n),
    .bo_det_i(bo_det), .core_clk_en_o(en), .tc_tick_o(tick), .restart_o(restart),
    .resume_o(resume), .halted_o(halted), .wake_src_o(wsrc),
    .wdt_pre_o(pre), .wdt_cnt_o(cnt)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_src(bit r, bit b, bit m, bit g, bit boen, logic [1:0] opt);
    if (r) return 0;
    if (b && boen) return 1;
    if (m) return 2;
    if (g && opt != 2'd0) return 3;
    return -1;
  endfunction

  task automatic run_case(logic [1:0] opt, bit boen, bit r, bit b, bit m, bit g);
    int src;
    int n;
    bit dly;
    @(negedge clk);
    clk_opt = opt; bo_en = boen; halt_wr = 1'b1;
    @(negedge clk);
    halt_wr = 1'b0;
    chk("R2", en, 0);
    chk("R2", halted, 1);
    repeat (3) @(negedge clk);
    chk("R2", en, 0);
    rstpin_n = ~r; bo_det = b; mwake = m; g7 = g;
    src = exp_src(r, b, m, g, boen, opt);
    if (src < 0) begin
      repeat (8) @(negedge clk);
      if (g) chk("R5", en, 0);
      else   chk("R6", en, 0);
      rstpin_n = 1'b0;
      src = 0;
    end
    dly = (opt == 2'd0) && (src == 1 || src == 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (!dly) begin
      if (src == 0 && opt == 2'd0) chk("R11", en, 1);
      else                         chk("R4", en, 1);
    end else begin
      chk("R10", en, 0);
      n = 0;
      while (!en && n < 400) begin
        if (tick) n++;
        @(negedge clk);
      end
      chk("R10", n, 256);
    end
    chk("R8", restart, int'(src < 2));
    chk("R8", resume, int'(src >= 2));
    chk("R7", wsrc, src);
    chk("R9", pre, 255);
    chk("R9", cnt, 255);
    @(negedge clk);
    chk("R8", int'(restart | resume), 0);
    rstpin_n = 1'b1; bo_det = 1'b0; mwake = 1'b0; g7 = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", en, 1); chk("R1", halted, 0); chk("R1", restart, 0);
    chk("R1", resume, 0); chk("R1", wsrc, 0); chk("R1", pre, 0); chk("R1", cnt, 0);

    // R3: tick spacing
    begin
      int n = 0;
      while (!tick) @(negedge clk);
      @(negedge clk); n = 1;
      while (!tick) begin @(negedge clk); n++; end
      chk("R3", n, 10);
    end

    // R12, R5: inputs while running
    g7 = 1'b1; mwake = 1'b1; bo_en = 1'b1; bo_det = 1'b1; rstpin_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R12", en, 1);
      chk("R5", int'(restart | resume), 0);
    end
    g7 = 1'b0; mwake = 1'b0; bo_det = 1'b0; rstpin_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed corners
    run_case(2'd0, 1'b0, 0, 0, 1, 0); // R10 crystal wakeup
    run_case(2'd0, 1'b1, 0, 1, 0, 0); // R10 crystal brown-out
    run_case(2'd0, 1'b1, 1, 0, 0, 0); // R11
    run_case(2'd0, 1'b0, 0, 0, 0, 1); // R5 g7 ignored on crystal
    run_case(2'd1, 1'b0, 0, 0, 0, 1); // R5 RC
    run_case(2'd2, 1'b0, 0, 0, 0, 1); // R5 external
    run_case(2'd1, 1'b0, 0, 1, 0, 0); // R6 disabled
    run_case(2'd1, 1'b1, 1, 1, 1, 1); // R7
    run_case(2'd2, 1'b1, 0, 1, 1, 1); // R7
    run_case(2'd1, 1'b1, 0, 0, 1, 1); // R7
    run_case(2'd1, 1'b1, 0, 1, 0, 0); // R9 RC preset

    for (int k = 0; k < 40; k++) begin
      logic [1:0] o;
      o = 2'($urandom % 3);
      run_case(o, 1'($urandom % 2), ($urandom % 4) == 0, ($urandom % 3) == 0,
               ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule